// File: doc/BRIEF.md
# Asynchronous SRAM Read Timing Engine

This block runs single-beat asynchronous read accesses against an external SRAM or NOR device. A requester offers an address on a valid/ready request port. Once the engine takes it, the engine drives the device: chip enable goes low for a programmed number of memory-clock cycles, and output enable follows after a programmed delay. The address stays fixed on the device pins for the whole access, and write enable never asserts.

The device's data is sampled on the falling clock edge inside the last cycle of the access. The sampled word goes into a small first-in-first-out queue, and the requester reads it from there with a pop strobe. The read-cycle count and the enable-to-output delay are taken from the configuration inputs at the moment a request is accepted. Changing them during an access has no effect on that access. Requests are only accepted while the mode inputs select asynchronous single-beat operation.

Top module: `sram_rd_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1 and rd_valid is 0. With a valid mode and no access running, req_ready is 1.
- R2: A request is accepted only when cfg_rd_sync is 0 and cfg_rd_bl is 3'b000. With any other mode value, req_ready stays 0 and no access starts even if req_valid is held high.
- R3: req_ready is 0 while an access is running (mem_ce_n low) and while the queue already holds FIFO_DEPTH words.
- R4: mem_ce_n goes low in the cycle after the accepting edge and stays low for exactly N cycles, where N = cfg_trc when cfg_trc is nonzero and N = 1 when cfg_trc is 0.
- R5: Number the access cycles 0 to N-1. mem_oe_n is low in every cycle c with c >= D, where D = min(cfg_tceoe, N-1), and high in all other cycles. The clamp guarantees that output enable covers at least the final cycle.
- R6: mem_we_n stays 1 at all times. mem_addr equals the accepted req_addr in every cycle of the access.
- R7: The device data present at the falling edge of cycle N-1 is stored as exactly one queue entry per access. rd_valid is 1 in the cycle after the access ends.
- R8: The queue returns words in the order the accesses were made. rd_data shows the oldest word, and the word is removed when rd_pop and rd_valid are both high at a rising edge.
- R9: cfg_trc and cfg_tceoe are sampled at acceptance. Changing them during an access changes neither the chip-enable length nor the output-enable start of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; data is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trc | input | 4 | Read cycle length in clocks (0 is treated as 1) |
| cfg_tceoe | input | 3 | Delay from chip enable to output enable in clocks |
| cfg_rd_sync | input | 1 | Read mode; must be 0 (asynchronous) for requests to be accepted |
| cfg_rd_bl | input | 3 | Read burst length; must be 000 (single beat) for requests to be accepted |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW | Address of the requested read |
| req_ready | output | 1 | Engine can take a request this cycle |
| mem_addr | output | AW | Device address |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low, held high |
| mem_rdata | input | DW | Data driven by the device |
| rd_valid | output | 1 | Queue holds at least one word |
| rd_data | output | DW | Oldest queued word |
| rd_pop | input | 1 | Remove the oldest word |

## Verification
The hardest case to reach from the ports is the clamp on output enable, where the programmed delay is at least the cycle length. A second hard case is the window where the data is sampled, because output enable may only just have asserted. The bench sweeps every pair of cycle length and delay values. Its device model returns a recognisable poison word whenever output enable is high, so a sample taken too early or a clamp that misses the final cycle shows up in the queued data. Each access also scrambles the configuration while it runs, which checks that the values were captured at acceptance. A burst of reads without pops fills the queue and reaches the full-queue hold-off.

// File: rtl/sre_pkg.sv
package sre_pkg;
    localparam int TRC_W = 4;
    localparam int OED_W = 3;
    localparam int BL_W  = 3;

    typedef struct packed {
        logic             busy;
        logic [TRC_W-1:0] cyc;
        logic [TRC_W-1:0] last;
        logic [TRC_W-1:0] oe_at;
    } ctrl_st_t;
endpackage

// File: rtl/sre_ctrl.sv
module sre_ctrl
    import sre_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TRC_W-1:0] cfg_trc,
    input  logic [OED_W-1:0] cfg_tceoe,
    input  logic             cfg_rd_sync,
    input  logic [BL_W-1:0]  cfg_rd_bl,
    input  logic             q_full,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             strobe
);
    ctrl_st_t         st_d, st_q;
    logic [AW-1:0]    addr_d, addr_q;
    logic             mode_ok;
    logic [TRC_W-1:0] len_eff;
    logic [TRC_W-1:0] oed_ext;

    always_comb begin
        mode_ok   = (cfg_rd_sync == 1'b0) && (cfg_rd_bl == '0);
        req_ready = !st_q.busy && !q_full && mode_ok;
        len_eff   = (cfg_trc == '0) ? TRC_W'(1) : cfg_trc;
        oed_ext   = TRC_W'(cfg_tceoe);
        strobe    = st_q.busy && (st_q.cyc == st_q.last);

        st_d   = st_q;
        addr_d = addr_q;
        if (st_q.busy) begin
            if (strobe) begin
                st_d.busy = 1'b0;
                st_d.cyc  = '0;
            end else begin
                st_d.cyc = st_q.cyc + 1'b1;
            end
        end else if (req_valid && req_ready) begin
            st_d.busy  = 1'b1;
            st_d.cyc   = '0;
            st_d.last  = len_eff - 1'b1;
            st_d.oe_at = (oed_ext >= len_eff) ? (len_eff - 1'b1) : oed_ext;
            addr_d     = req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            addr_q <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
        end
    end

    assign mem_addr = addr_q;
    assign mem_ce_n = !st_q.busy;
    assign mem_oe_n = !(st_q.busy && (st_q.cyc >= st_q.oe_at));
endmodule

// File: rtl/sre_capture.sv
module sre_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = strobe ? din : cap_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign dout = cap_q;
endmodule

// File: rtl/sre_fifo.sv
module sre_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic          full,
    output logic          valid,
    output logic [DW-1:0] rdata
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic [DW-1:0] slot_q [DEPTH];
    logic          do_push, do_pop;

    always_comb begin
        valid   = (cnt_q != '0);
        full    = (cnt_q == CW'(DEPTH));
        do_pop  = pop && valid;
        do_push = push && (!full || do_pop);
        wp_d    = wp_q;
        rp_d    = rp_q;
        cnt_d   = cnt_q;
        if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
        if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
        if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
        if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
        rdata = slot_q[rp_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot_q[i] <= '0;
            else if (do_push && wp_q == PW'(i))  slot_q[i] <= wdata;
        end
    end
endmodule

// File: rtl/sram_rd_engine.sv
module sram_rd_engine
    import sre_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TRC_W-1:0] cfg_trc,
    input  logic [OED_W-1:0] cfg_tceoe,
    input  logic             cfg_rd_sync,
    input  logic [BL_W-1:0]  cfg_rd_bl,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    input  logic [DW-1:0]    mem_rdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    input  logic             rd_pop
);
    logic          strobe;
    logic          q_full;
    logic [DW-1:0] cap_data;

    sre_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_trc    (cfg_trc),
        .cfg_tceoe  (cfg_tceoe),
        .cfg_rd_sync(cfg_rd_sync),
        .cfg_rd_bl  (cfg_rd_bl),
        .q_full     (q_full),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .strobe     (strobe)
    );

    sre_capture #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(strobe),
        .din   (mem_rdata),
        .dout  (cap_data)
    );

    sre_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (strobe),
        .wdata(cap_data),
        .pop  (rd_pop),
        .full (q_full),
        .valid(rd_valid),
        .rdata(rd_data)
    );

    assign mem_we_n = 1'b1;
endmodule

// File: rtl/sram_rd_engine_chk.sv
module sram_rd_engine_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic          req_ready,
    input logic          rd_valid
);
    // R6
    we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n == 1'b1);

    // R5
    oe_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R5
    oe_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mem_oe_n) && !mem_ce_n) |-> !mem_oe_n);

    // R6
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R7
    word_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> rd_valid);
endmodule

bind sram_rd_engine sram_rd_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_addr (mem_addr),
    .req_ready(req_ready),
    .rd_valid (rd_valid)
);

// File: tb/sram_rd_engine_test.sv
module sram_rd_engine_test;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int FD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_trc = 4'd3;
    logic [2:0]    cfg_tceoe = 3'd1;
    logic          cfg_rd_sync = 1'b0;
    logic [2:0]    cfg_rd_bl = 3'b000;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] mem_rdata;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_pop = 1'b0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] dev_word(input logic [AW-1:0] a);
        return (DW'(a) * 16'd5) ^ 16'hA5C3;
    endfunction

    // device model: poison word while output enable is high
    assign mem_rdata = !mem_oe_n ? dev_word(mem_addr) : 16'hDEAD;

    sram_rd_engine #(.AW(AW), .DW(DW), .FIFO_DEPTH(FD)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_trc(cfg_trc), .cfg_tceoe(cfg_tceoe),
        .cfg_rd_sync(cfg_rd_sync), .cfg_rd_bl(cfg_rd_bl),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_pop(rd_pop)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One access; pop afterwards when do_pop is set
    task automatic run_access(input logic [AW-1:0] a, input int trc, input int oed,
                              input bit do_pop);
        int n;
        int d;
        n = (trc == 0) ? 1 : trc;
        d = (oed > n - 1) ? n - 1 : oed;
        @(negedge clk);
        cfg_trc = 4'(trc);
        cfg_tceoe = 3'(oed);
        req_addr = a;
        chk(req_ready == 1'b1, "R2 ready in async single mode", int'(req_ready), 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R9: scramble configuration during the access
        cfg_trc = ~4'(trc);
        cfg_tceoe = ~3'(oed);
        req_addr = ~a;
        for (int c = 0; c < n; c++) begin
            chk(mem_ce_n == 1'b0, "R4 R9 ce low in access", int'(mem_ce_n), 0);
            chk(mem_oe_n == (c < d), "R5 R9 oe timing", int'(mem_oe_n), int'(c < d));
            chk(mem_addr == a, "R6 address held", int'(mem_addr), int'(a));
            chk(mem_we_n == 1'b1, "R6 we high", int'(mem_we_n), 1);
            chk(req_ready == 1'b0, "R3 not ready while busy", int'(req_ready), 0);
            if (c != n - 1) @(negedge clk);
        end
        @(negedge clk);
        chk(mem_ce_n == 1'b1, "R4 ce released after N", int'(mem_ce_n), 1);
        chk(mem_oe_n == 1'b1, "R5 oe released", int'(mem_oe_n), 1);
        chk(rd_valid == 1'b1, "R7 word queued", int'(rd_valid), 1);
        cfg_trc = 4'(trc);
        cfg_tceoe = 3'(oed);
        if (do_pop) begin
            chk(rd_data == dev_word(a), "R7 captured data", int'(rd_data), int'(dev_word(a)));
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
            chk(rd_valid == 1'b0, "R8 pop empties queue", int'(rd_valid), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset",
            int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        chk(rd_valid == 1'b0, "R1 queue empty in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(mem_ce_n == 1'b1, "R1 ce idle after reset", int'(mem_ce_n), 1);

        // full sweep of cycle length and delay
        for (int t = 0; t < 16; t++) begin
            for (int d = 0; d < 8; d++) begin
                run_access(AW'(t * 37 + d * 5 + 1), t, d, 1'b1);
            end
        end

        // R2: other modes block requests
        @(negedge clk);
        cfg_rd_sync = 1'b1;
        req_valid = 1'b1;
        req_addr = 12'h123;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R2 sync mode blocks", int'(req_ready), 0);
            chk(mem_ce_n == 1'b1, "R2 no access in sync mode", int'(mem_ce_n), 1);
        end
        cfg_rd_sync = 1'b0;
        cfg_rd_bl = 3'b010;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R2 burst length blocks", int'(req_ready), 0);
            chk(mem_ce_n == 1'b1, "R2 no access in burst mode", int'(mem_ce_n), 1);
        end
        req_valid = 1'b0;
        cfg_rd_bl = 3'b000;

        // R3 / R8: fill queue, then drain in order
        for (int k = 0; k < FD; k++) run_access(AW'(12'h400 + k * 9), 2, 0, 1'b0);
        @(negedge clk);
        chk(req_ready == 1'b0, "R3 not ready when queue full", int'(req_ready), 0);
        req_valid = 1'b1;
        req_addr = 12'h7FF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(mem_ce_n == 1'b1, "R3 no access when full", int'(mem_ce_n), 1);
        end
        req_valid = 1'b0;
        for (int k = 0; k < FD; k++) begin
            chk(rd_valid == 1'b1, "R8 word present", int'(rd_valid), 1);
            chk(rd_data == dev_word(AW'(12'h400 + k * 9)), "R8 order",
                int'(rd_data), int'(dev_word(AW'(12'h400 + k * 9))));
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
        chk(rd_valid == 1'b0, "R8 drained", int'(rd_valid), 0);
        chk(req_ready == 1'b1, "R3 ready again after drain", int'(req_ready), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule